// File: doc/BRIEF.md
# DMA Burst Size Planner

This block sits in front of a DMA engine's system-bus master and turns a pending transfer of N beats into a sequence of bus transactions. Each transaction carries a start address, a burst kind and a beat count. A request is accepted with a one-cycle `start` pulse. That pulse latches the direction (transmit or receive), the descriptor-read flag, the fixed-burst enable and the programmed maximum burst length. The planner then walks the remaining length down one transaction at a time.

Before each transaction the planner checks FIFO readiness. On transmit, `fifo_level` is the free space in beats. On receive, it is the fill level in beats, and `fifo_eof` says that the frame's end is already in the FIFO. Descriptor reads bypass the FIFO check. With fixed bursts enabled, the planner uses bursts of 16, 8 or 4 beats and single beats. On receive, a short tail is padded up to a 4-beat burst with dummy beats. With fixed bursts disabled, it uses undefined-length incrementing bursts and singles.

The controller has four states:
- `ST_IDLE` waits for `start`. It moves to `ST_GATE`, or to `ST_DONE` when the length is zero.
- `ST_GATE` waits for FIFO readiness and loads the next transaction. It moves to `ST_ISSUE`.
- `ST_ISSUE` presents the transaction for one cycle. It returns to `ST_GATE` while beats remain, and otherwise moves to `ST_DONE`.
- `ST_DONE` signals completion for one cycle and returns to `ST_IDLE`.

Top module: `burst_planner`

## Requirements
- R1: After reset, and whenever `busy` is 0, `txn_valid` and `done` are 0.
- R2: With `fixed_burst`=1, every transaction uses one of these `txn_kind` values: 2 (4-beat fixed), 3 (8-beat fixed), 4 (16-beat fixed) or 0 (single, 1 beat). The planner picks the largest fixed size that is at most min(remaining, maximum). When no fixed size fits, it issues a single beat.
- R3: The data beats of a transaction (`txn_beats` minus `txn_pad`) never exceed the effective maximum. The effective maximum is `max_burst`, with 0 read as 1.
- R4: With `fixed_burst`=0, a transaction is kind 1 (incrementing) of min(remaining, maximum) beats when that value is at least 2. Otherwise it is kind 0 with 1 beat.
- R5: A receive data transfer (`req_rx`=1, `req_desc`=0) with `fixed_burst`=1 and maximum ≥ 4 sends a remaining 1 to 3 beats as kind 2. In that case `txn_beats`=4 and `txn_pad` = 4 − remaining dummy beats. In every other case `txn_pad` is 0.
- R6: On transmit (`req_rx`=0, `req_desc`=0), a transaction is issued only when `fifo_level` ≥ min(maximum, remaining).
- R7: On receive, a transaction is issued only when `fifo_level` ≥ maximum, or when `fifo_eof`=1 and `fifo_level` ≥ remaining.
- R8: Descriptor reads (`req_desc`=1) ignore `fifo_level` and `fifo_eof`. They split like transmit and are never padded.
- R9: The first transaction starts at `req_addr`. Each later one starts 4 bytes per data beat of the one before.
- R10: The data beats of all transactions add up to `req_len`. `done` pulses for one cycle after the last transaction. A zero-length request gives `done` with no transaction.
- R11: `txn_valid` is never high on two cycles in a row. A `start` pulse while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| req_addr | input | ADDR_W | Start byte address of the transfer |
| req_len | input | LEN_W | Transfer length in beats |
| req_rx | input | 1 | 1 = receive direction, 0 = transmit |
| req_desc | input | 1 | 1 = descriptor read, with no FIFO check |
| fixed_burst | input | 1 | 1 = fixed 4/8/16 bursts, 0 = incrementing bursts |
| max_burst | input | MAXB_W | Maximum burst in beats, with 0 read as 1 |
| fifo_level | input | LVL_W | Free beats (transmit) or held beats (receive) |
| fifo_eof | input | 1 | Frame end is present in the receive FIFO |
| txn_valid | output | 1 | Transaction fields are valid this cycle |
| txn_addr | output | ADDR_W | Transaction start address |
| txn_kind | output | 3 | 0 single, 1 incrementing, 2/3/4 fixed 4/8/16 |
| txn_beats | output | LEN_W | Bus beats, including dummy beats |
| txn_pad | output | 2 | Dummy beats at the end of the burst |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The padded tail is the hardest case to reach. It needs several conditions at once: receive direction, not a descriptor read, fixed bursts, a maximum of at least 4, and a length whose greedy split leaves 1 to 3 beats. A second hard case is a stalled gate where receive data is short of a full burst but the frame end has not yet arrived. The stimulus sends directed lengths of 31 and 5 with these settings. It holds the FIFO level below the burst for several cycles and then raises `fifo_eof`. Random requests over all modes, lengths 0 to 100 and maxima 0 to 32 cover the remaining combinations.

// File: rtl/burst_plan_pkg.sv
package burst_plan_pkg;

    typedef enum logic [2:0] {
        KIND_SINGLE = 3'd0,
        KIND_INCR   = 3'd1,
        KIND_FIX4   = 3'd2,
        KIND_FIX8   = 3'd3,
        KIND_FIX16  = 3'd4
    } bkind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } pstate_t;

endpackage

// File: rtl/burst_pick.sv
// Chooses the kind and size of the next transaction from the remaining beats.
module burst_pick
    import burst_plan_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [LEN_W-1:0] rem,
    input  logic [LEN_W-1:0] maxe,
    input  logic             fixed,
    input  logic             pad_ok,
    output bkind_t           kind,
    output logic [LEN_W-1:0] data_beats,
    output logic [1:0]       pad
);
    localparam logic [LEN_W-1:0] N1  = LEN_W'(1);
    localparam logic [LEN_W-1:0] N2  = LEN_W'(2);
    localparam logic [LEN_W-1:0] N4  = LEN_W'(4);
    localparam logic [LEN_W-1:0] N8  = LEN_W'(8);
    localparam logic [LEN_W-1:0] N16 = LEN_W'(16);

    logic [LEN_W-1:0] lim;

    always_comb begin
        lim        = (rem < maxe) ? rem : maxe;
        kind       = KIND_SINGLE;
        data_beats = N1;
        pad        = 2'd0;
        if (fixed) begin
            if (lim >= N16) begin
                kind       = KIND_FIX16;
                data_beats = N16;
            end else if (lim >= N8) begin
                kind       = KIND_FIX8;
                data_beats = N8;
            end else if (lim >= N4) begin
                kind       = KIND_FIX4;
                data_beats = N4;
            end else if (pad_ok && maxe >= N4) begin
                kind       = KIND_FIX4;
                data_beats = rem;
                pad        = 2'(3'd4 - rem[2:0]);
            end
        end else if (lim >= N2) begin
            kind       = KIND_INCR;
            data_beats = lim;
        end
    end
endmodule

// File: rtl/fifo_gate.sv
// Decides whether the FIFO can take (transmit) or supply (receive) the next burst.
module fifo_gate #(
    parameter int LEN_W = 12,
    parameter int LVL_W = 8
) (
    input  logic             rx,
    input  logic             desc,
    input  logic [LVL_W-1:0] level,
    input  logic             eof,
    input  logic [LEN_W-1:0] rem,
    input  logic [LEN_W-1:0] maxe,
    output logic             ready
);
    logic [LEN_W-1:0] lvl_x;
    logic [LEN_W-1:0] need;

    always_comb begin
        lvl_x = LEN_W'(level);
        need  = (rem < maxe) ? rem : maxe;
        if (desc) begin
            ready = 1'b1;
        end else if (rx) begin
            ready = (lvl_x >= maxe) || (eof && (lvl_x >= rem));
        end else begin
            ready = (lvl_x >= need);
        end
    end
endmodule

// File: rtl/burst_planner.sv
module burst_planner
    import burst_plan_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int MAXB_W     = 6,
    parameter int LVL_W      = 8,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_rx,
    input  logic              req_desc,
    input  logic              fixed_burst,
    input  logic [MAXB_W-1:0] max_burst,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              fifo_eof,
    output logic              txn_valid,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [2:0]        txn_kind,
    output logic [LEN_W-1:0]  txn_beats,
    output logic [1:0]        txn_pad,
    output logic              busy,
    output logic              done
);
    localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

    pstate_t          state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic             rx_q, desc_q, fixed_q;
    logic [LEN_W-1:0] maxe_q;

    bkind_t           pick_kind;
    logic [LEN_W-1:0] pick_data;
    logic [1:0]       pick_pad;
    logic             gate_ok;

    logic [ADDR_W-1:0] addr_r;
    bkind_t            kind_r;
    logic [LEN_W-1:0]  beats_r;
    logic [1:0]        pad_r;

    burst_pick #(.LEN_W(LEN_W)) pick_i (
        .rem        (rem_q),
        .maxe       (maxe_q),
        .fixed      (fixed_q),
        .pad_ok     (rx_q && !desc_q),
        .kind       (pick_kind),
        .data_beats (pick_data),
        .pad        (pick_pad)
    );

    fifo_gate #(.LEN_W(LEN_W), .LVL_W(LVL_W)) gate_i (
        .rx    (rx_q),
        .desc  (desc_q),
        .level (fifo_level),
        .eof   (fifo_eof),
        .rem   (rem_q),
        .maxe  (maxe_q),
        .ready (gate_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (req_len == '0) ? ST_DONE : ST_GATE;
            ST_GATE:  if (gate_ok) state_d = ST_ISSUE;
            ST_ISSUE: state_d = (rem_q == '0) ? ST_DONE : ST_GATE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Request bookkeeping and transaction fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            addr_q  <= '0;
            rx_q    <= 1'b0;
            desc_q  <= 1'b0;
            fixed_q <= 1'b0;
            maxe_q  <= LEN_W'(1);
            addr_r  <= '0;
            kind_r  <= KIND_SINGLE;
            beats_r <= '0;
            pad_r   <= 2'd0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    rem_q   <= req_len;
                    addr_q  <= req_addr;
                    rx_q    <= req_rx;
                    desc_q  <= req_desc;
                    fixed_q <= fixed_burst;
                    maxe_q  <= (max_burst == '0) ? LEN_W'(1) : LEN_W'(max_burst);
                end
                ST_GATE: if (gate_ok) begin
                    addr_r  <= addr_q;
                    kind_r  <= pick_kind;
                    beats_r <= pick_data + LEN_W'(pick_pad);
                    pad_r   <= pick_pad;
                    rem_q   <= rem_q - pick_data;
                    addr_q  <= addr_q + (ADDR_W'(pick_data) << BEAT_SHIFT);
                end
                default: ;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        txn_valid = (state_q == ST_ISSUE);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        txn_addr  = addr_r;
        txn_kind  = kind_r;
        txn_beats = beats_r;
        txn_pad   = pad_r;
    end
endmodule

// File: rtl/burst_planner_chk.sv
module burst_planner_chk
    import burst_plan_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             txn_valid,
    input logic [2:0]       txn_kind,
    input logic [LEN_W-1:0] txn_beats,
    input logic [1:0]       txn_pad,
    input logic [LEN_W-1:0] maxe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!txn_valid && !done));

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> !txn_valid);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R3
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_beats - LEN_W'(txn_pad)) <= maxe));

    // R5
    pad_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_pad != 2'd0) |-> (txn_kind == 3'd2 && txn_beats == LEN_W'(4)));

    // R2
    fix16_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_kind == 3'd4) |-> (txn_beats == LEN_W'(16)));

    // R2
    fix8_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_kind == 3'd3) |-> (txn_beats == LEN_W'(8)));

    // R4
    single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_kind == 3'd0) |-> (txn_beats == LEN_W'(1)));
endmodule

bind burst_planner burst_planner_chk #(.LEN_W(LEN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .txn_valid (txn_valid),
    .txn_kind  (txn_kind),
    .txn_beats (txn_beats),
    .txn_pad   (txn_pad),
    .maxe      (maxe_q)
);

// File: tb/burst_planner_tb_top.sv
`timescale 1ns/1ps
module burst_planner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        req_rx = 1'b0, req_desc = 1'b0, fixed_burst = 1'b0;
    logic [5:0]  max_burst = '0;
    logic [7:0]  fifo_level = '0;
    logic        fifo_eof = 1'b0;
    logic        txn_valid;
    logic [31:0] txn_addr;
    logic [2:0]  txn_kind;
    logic [11:0] txn_beats;
    logic [1:0]  txn_pad;
    logic        busy, done;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_planner dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
        .req_len(req_len), .req_rx(req_rx), .req_desc(req_desc),
        .fixed_burst(fixed_burst), .max_burst(max_burst),
        .fifo_level(fifo_level), .fifo_eof(fifo_eof),
        .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_kind(txn_kind),
        .txn_beats(txn_beats), .txn_pad(txn_pad), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected split of the next transaction, from R2/R4/R5
    task automatic model(input bit fb, input bit padok, input int mb, input int rem,
                         output int kind, output int data, output int pad);
        int me;
        int lim;
        me   = (mb == 0) ? 1 : mb;
        lim  = (rem < me) ? rem : me;
        pad  = 0;
        kind = 0;
        data = 1;
        if (fb) begin
            if (lim >= 16) begin kind = 4; data = 16; end
            else if (lim >= 8) begin kind = 3; data = 8; end
            else if (lim >= 4) begin kind = 2; data = 4; end
            else if (padok && me >= 4) begin kind = 2; data = rem; pad = 4 - rem; end
        end else if (lim >= 2) begin
            kind = 1; data = lim;
        end
    endtask

    task automatic setup(input bit rx, input bit dsc, input bit fb, input int mb,
                         input int len, input logic [31:0] a, input int lvl, input bit eof);
        @(negedge clk);
        req_rx = rx; req_desc = dsc; fixed_burst = fb; max_burst = 6'(mb);
        req_len = 12'(len); req_addr = a; fifo_level = 8'(lvl); fifo_eof = eof;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Follow a started request to its done pulse, comparing every transaction
    task automatic collect(input bit rx, input bit dsc, input bit fb, input int mb,
                           input int len, input logic [31:0] a);
        int rem;
        logic [31:0] ad;
        int guard;
        int k, d, p;
        string tag;
        bit fin;
        rem = len; ad = a; guard = 0; fin = 0;
        while (!fin && guard < 3000) begin
            if (txn_valid) begin
                model(fb, rx && !dsc, mb, rem, k, d, p);
                tag = (p != 0) ? "R5" : (dsc ? "R8" : (fb ? "R2" : "R4"));
                check(txn_kind == 3'(k) && txn_beats == 12'(d + p) && txn_pad == 2'(p),
                      tag, "kind*100+beats*10+pad (R3 cap)",
                      txn_kind * 100 + txn_beats * 10 + txn_pad, k * 100 + (d + p) * 10 + p);
                check(txn_addr == ad, "R9", "txn_addr", txn_addr, ad);
                rem = rem - d;
                ad  = ad + 32'(d * 4);
            end
            if (done) begin
                check(rem == 0, "R10", "beats left at done", rem, 0);
                fin = 1;
            end
            if (!fin) begin
                @(negedge clk);
                guard++;
            end
        end
        if (!fin) check(0, "R10", "done never seen", 0, 1);
        @(negedge clk);
    endtask

    task automatic run_req(input bit rx, input bit dsc, input bit fb, input int mb,
                           input int len, input logic [31:0] a, input int lvl, input bit eof);
        setup(rx, dsc, fb, mb, len, a, lvl, eof);
        collect(rx, dsc, fb, mb, len, a);
    endtask

    task automatic hold_idle(input int cycles, input string req);
        bit seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (txn_valid) seen = 1;
            @(negedge clk);
        end
        check(!seen && busy, req, "transaction while gated (busy expected)", seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!txn_valid && !busy && !done, "R1", "outputs in reset",
              {txn_valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!txn_valid && !busy && !done, "R1", "outputs after reset",
              {txn_valid, busy, done}, 0);

        // R2: greedy fixed split on transmit: 16,8,4,1,1,1
        run_req(0, 0, 1, 16, 31, 32'h1000, 255, 0);
        // R5: same length on receive ends with a padded 4-beat burst
        run_req(1, 0, 1, 16, 31, 32'h2000, 255, 1);
        // R3: max below 4 in fixed mode gives singles only
        run_req(1, 0, 1, 2, 6, 32'h3000, 255, 1);
        // R4: incrementing bursts capped by max, max 0 read as 1
        run_req(0, 0, 0, 12, 29, 32'h4000, 255, 0);
        run_req(0, 0, 0, 0, 3, 32'h4100, 255, 0);
        // R10: zero length
        run_req(0, 0, 1, 16, 0, 32'h5000, 255, 0);

        // R6 and R11: transmit gated by free space, start ignored while busy
        setup(0, 0, 0, 16, 40, 32'h6000, 15, 0);
        hold_idle(4, "R6");
        start = 1'b1; req_len = 12'd3;
        @(negedge clk);
        start = 1'b0; req_len = 12'd40;
        hold_idle(5, "R11");
        fifo_level = 8'd16;
        collect(0, 0, 0, 16, 40, 32'h6000);

        // R7: receive waits for a full burst or frame end
        setup(1, 0, 1, 8, 5, 32'h7000, 5, 0);
        hold_idle(8, "R7");
        fifo_eof = 1'b1;
        collect(1, 0, 1, 8, 5, 32'h7000);

        // R8: descriptor read ignores an empty FIFO
        run_req(1, 1, 1, 16, 7, 32'h8000, 0, 0);
        run_req(0, 1, 0, 8, 8, 32'h8100, 0, 0);

        // Random mix over all modes
        for (int i = 0; i < 80; i++) begin
            bit rx, dsc, fb;
            int mb, len;
            logic [31:0] a;
            rx  = 1'($urandom_range(0, 1));
            dsc = ($urandom_range(0, 3) == 0);
            fb  = 1'($urandom_range(0, 1));
            mb  = $urandom_range(0, 32);
            len = $urandom_range(0, 100);
            a   = {$urandom_range(0, 32'h0FFF_FFFF), 2'b00};
            run_req(rx, dsc, fb, mb, len, a, 255, 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule